// File: doc/BRIEF.md
# Burst SRAM Read-Data Output Stage

This block is the read side of a synchronous burst SRAM. Each rising edge loads a command into the input registers: select, write flag, word address, write data and a byte-lane mask. The word stored at the registered address then goes to a 32-bit data bus. The bus is modelled as a data vector `rd_data` plus a drive flag `rd_drive`. When `rd_drive` is low, the bus stands for high impedance and `rd_data` is held at zero.

A static latency input picks between two behaviours. In flow-through mode (`pipe_mode` low), the word is on the bus in the same cycle its address is held in the input registers. In pipelined mode (`pipe_mode` high), the word first passes through a rising-edge output register and appears one cycle later. Pipelined is the default that an integrator should tie. `pipe_mode` may only change while `rst_n` is low.

Turn-off follows a single-cycle-deselect rule. A deselect or a write held in the input registers releases the bus in that same cycle, one stage ahead of where read data would arrive. The output enable `oe_n` is asynchronous. It can drop the drive at any moment, but it can only restore drive that a read has set up. The bus edge is a plain synchronous memory port: there is no valid/ready handshake and no back-pressure. A command is accepted on every edge.

Top module: `burst_dout_path`

## Requirements
- R1: While `rst_n` is low, and after it is released, until a read reaches the bus, `rd_drive` is 0 and `rd_data` is 0. Reset clears the output register and the input registers.
- R2: With `pipe_mode`=0, a read is captured at edge k (`sel`=1, `wr`=0). Between edges k and k+1, `rd_drive`=1 and `rd_data` equals the stored word at that address, provided `oe_n`=0.
- R3: With `pipe_mode`=1, a read is captured at edge k and a read is also captured at edge k+1. Between edges k+1 and k+2, `rd_drive`=1 and `rd_data` equals the word read at edge k.
- R4: When a deselect (`sel`=0) is captured at edge m, `rd_drive` is 0 between m and m+1 in both modes. In pipelined mode this applies even when the output register holds a word from a read at m-1.
- R5: When a write (`sel`=1, `wr`=1) is captured at edge m, `rd_drive` is 0 between m and m+1 in both modes, for any value of `byte_we`.
- R6: A write updates only the lanes whose `byte_we[i]`=1, where lane i is bits 8i+7..8i. With `byte_we`=0000 nothing changes. The store is updated at the edge after capture, so a read captured at that same edge already returns the new word.
- R7: A read drives all four lanes with the stored word, whatever value `byte_we` has in the read command.
- R8: `oe_n`=1 forces `rd_drive` to 0 combinationally, within the same cycle. `oe_n`=0 yields `rd_drive`=1 only in a cycle where R2 or R3 makes data valid.
- R9: Whenever `rd_drive` is 0, `rd_data` is 0.
- R10: In pipelined mode, a run of back-to-back reads delivers one word per cycle in command order, each one cycle later than in flow-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined; static |
| sel | input | 1 | Chip select for the command on this edge |
| wr | input | 1 | 1 = write command, 0 = read |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| byte_we | input | 4 | Per-lane write enable |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 32 | Bus data, zero when not driven |
| rd_drive | output | 1 | 1 = bus driven, 0 = high impedance |

## Verification
The bench targets the two places where the modes differ. The first is the last read of a pipelined burst followed directly by a deselect or a write. A design that pipelines the drive flag fully would drive stale data there, where the bus must float. The second is read latency: a design that registers in flow-through mode, or skips the register in pipelined mode, delivers every word one cycle off, and the per-cycle comparison reports it. The remaining cases each catch a specific fault:
- partial and empty byte masks expose a design that writes whole words;
- a read issued right after a write exposes one that returns pre-write data;
- an output enable raised in mid-cycle exposes one that samples `oe_n` on the clock.

// File: rtl/burst_dout_pkg.sv
package burst_dout_pkg;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;

  typedef struct packed {
    logic sel;
    logic wr;
  } cyc_kind_t;

endpackage

// File: rtl/burst_cmd_capture.sv
module burst_cmd_capture #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] byte_we,
  output burst_dout_pkg::cyc_kind_t q_kind,
  output logic [AW-1:0]    q_addr,
  output logic [DW-1:0]    q_wdata,
  output logic [LANES-1:0] q_be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_kind  <= '0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_be    <= '0;
    end else begin
      q_kind.sel <= sel;
      q_kind.wr  <= wr;
      q_addr     <= addr;
      q_wdata    <= wdata;
      q_be       <= byte_we;
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !q_kind.sel); // R1

endmodule

// File: rtl/burst_word_store.sv
module burst_word_store #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  burst_dout_pkg::cyc_kind_t kind,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be,
  output logic [DW-1:0]    rd_word
);

  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic do_write;
  assign do_write = kind.sel & kind.wr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (do_write && be[l]) lane_mem[addr] <= wdata[l*LW +: LW];
    end

    assign rd_word[l*LW +: LW] = lane_mem[addr];
  end

endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  burst_dout_pkg::cyc_kind_t kind,
  input  logic [DW-1:0] arr_word,
  input  logic          oe_n,
  output logic [DW-1:0] bus_data,
  output logic          bus_drive
);
  import burst_dout_pkg::*;

  localparam int LW = DW / LANES;

  lat_mode_e     mode;
  logic          rd_cyc;
  logic [DW-1:0] hold_data;
  logic          hold_drv;
  logic [DW-1:0] src_word;
  logic          core_drv;

  assign mode   = lat_mode_e'(pipe_mode);
  assign rd_cyc = kind.sel & ~kind.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_drv  <= 1'b0;
    end else begin
      if (rd_cyc) hold_data <= arr_word;
      hold_drv <= rd_cyc;
    end
  end

  always_comb begin
    if (mode == LAT_PIPE) begin
      src_word = hold_data;
      core_drv = hold_drv & rd_cyc;
    end else begin
      src_word = arr_word;
      core_drv = rd_cyc;
    end
  end

  assign bus_drive = core_drv & ~oe_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_gate
    assign bus_data[l*LW +: LW] = bus_drive ? src_word[l*LW +: LW] : '0;
  end

  AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_data == '0)); // R9
  AST_OE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_drive); // R8

endmodule

// File: rtl/burst_dout_path.sv
module burst_dout_path #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] byte_we,
  input  logic             oe_n,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive
);
  import burst_dout_pkg::*;

  cyc_kind_t        q_kind;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_wdata;
  logic [LANES-1:0] q_be;
  logic [DW-1:0]    arr_word;

  burst_cmd_capture #(.AW(AW), .DW(DW), .LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .byte_we(byte_we), .q_kind(q_kind), .q_addr(q_addr),
    .q_wdata(q_wdata), .q_be(q_be)
  );

  burst_word_store #(.AW(AW), .DW(DW), .LANES(LANES)) u_store (
    .clk(clk), .kind(q_kind), .addr(q_addr), .wdata(q_wdata),
    .be(q_be), .rd_word(arr_word)
  );

  burst_out_stage #(.DW(DW), .LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .kind(q_kind),
    .arr_word(arr_word), .oe_n(oe_n), .bus_data(rd_data), .bus_drive(rd_drive)
  );

  // Cycles since reset release, saturating; keeps $past inside valid history.
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd1) && $past(!sel) |-> !rd_drive); // R4
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd1) && $past(sel && wr) |-> !rd_drive); // R5
  AST_FLOW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd1) && !pipe_mode && $past(sel && !wr) && !oe_n |-> rd_drive); // R2
  AST_PIPE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) && pipe_mode && $past(sel && !wr, 2) && $past(sel && !wr)
    && !oe_n |-> rd_drive); // R3
  AST_PIPE_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) && pipe_mode && $past(!(sel && !wr), 2) |-> !rd_drive); // R10

endmodule

// File: tb/burst_dout_path_tb.sv
`timescale 1ns/100ps
module burst_dout_path_tb;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int LANES = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b1;
  logic sel = 1'b0, wr = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [LANES-1:0] byte_we = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_dout_path #(.AW(AW), .DW(DW), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .byte_we(byte_we), .oe_n(oe_n),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  // Reference model state (from the requirements)
  logic [DW-1:0] m_mem [DEPTH];
  logic m_sel, m_wr, m_pv;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_pd;
  logic [LANES-1:0] m_be;

  logic exp_drv_q[$];
  logic [DW-1:0] exp_dat_q[$];
  string exp_tag_q[$];

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s drive/data actual=%0d/%h expected=%0d/%h", tag,
               act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_wr = 0; m_pv = 0; m_addr = '0; m_wd = '0; m_pd = '0; m_be = '0;
  endtask

  // Driver: drives one command and pushes the expected bus for the window after the next edge.
  task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [LANES-1:0] be,
                      input logic o, input string tag);
    logic [DW-1:0] old_rd;
    logic rd_new, drv;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; byte_we = be; oe_n = o;
    old_rd = m_mem[m_addr];
    m_pv = m_sel & ~m_wr;
    if (m_pv) m_pd = old_rd;
    if (m_sel && m_wr)
      for (int l = 0; l < LANES; l++)
        if (m_be[l]) m_mem[m_addr][l*8 +: 8] = m_wd[l*8 +: 8];
    m_sel = s; m_wr = w; m_addr = a; m_wd = d; m_be = be;
    rd_new = s & ~w;
    drv = ~o & rd_new & (pipe_mode ? m_pv : 1'b1);
    exp_drv_q.push_back(drv);
    exp_dat_q.push_back(drv ? (pipe_mode ? m_pd : m_mem[a]) : '0);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_drv_q.size() > 0) begin
        logic ed;
        logic [DW-1:0] ex;
        string t;
        ed = exp_drv_q.pop_front();
        ex = exp_dat_q.pop_front();
        t  = exp_tag_q.pop_front();
        check(t, {rd_drive, rd_data}, {ed, ex});
      end
    end
  end

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 0; pipe_mode = mode; sel = 0; wr = 0; oe_n = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #3 check("R1 in reset", {rd_drive, rd_data}, '0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #3 check("R1 after release", {rd_drive, rd_data}, '0);
  endtask

  task automatic run_mode(input logic mode);
    string lt;
    lt = mode ? "R3 R10 pipelined read" : "R2 flow read";
    do_reset(mode);
    for (int i = 0; i < 6; i++)
      step(1, 1, AW'(i), 32'hA5000000 + 32'(i) * 32'h01010101 + (mode ? 32'h10 : 32'h0), 4'hF, 0, "R5 full write");
    step(1, 1, 4'd2, 32'h11223344, 4'b0101, 0, "R5 partial write");
    step(1, 0, 4'd2, '0, 4'h0, 0, "R6 read after partial write");
    step(1, 1, 4'd3, 32'hDEADBEEF, 4'b0000, 0, "R5 empty-mask write");
    step(1, 0, 4'd3, '0, 4'hF, 0, "R6 empty mask leaves word");
    step(1, 0, 4'd0, '0, 4'h0, 0, lt);
    step(1, 0, 4'd1, '0, 4'hA, 0, {lt, " R7"});
    step(1, 0, 4'd2, '0, 4'h5, 0, lt);
    step(1, 0, 4'd4, '0, 4'h0, 0, lt);
    step(0, 0, 4'd5, '0, 4'h0, 0, "R4 deselect after read");
    step(0, 0, 4'd5, '0, 4'h0, 0, "R4 deselect idle");
    step(1, 0, 4'd5, '0, 4'h0, 0, lt);
    step(1, 1, 4'd6, 32'h0BADF00D, 4'hF, 0, "R5 write after read");
    step(1, 0, 4'd6, '0, 4'h0, 1, "R8 oe high on read");
    step(1, 0, 4'd0, '0, 4'h0, 0, "R8 oe low re-enable");
    step(1, 0, 4'd1, '0, 4'h0, 0, "R8 oe low re-enable");
    step(1, 0, 4'd2, '0, 4'h0, 0, lt);
    // Raise oe_n in mid-cycle while the bus is driven
    @(posedge clk);
    #4 oe_n = 1;
    #0.5 check("R8 async oe", {rd_drive, rd_data}, '0);
    step(0, 0, 4'd0, '0, 4'h0, 0, "R4 R9 deselect");
    step(0, 0, 4'd0, '0, 4'h0, 0, "R9 idle");
    repeat (2) @(posedge clk);
  endtask

  initial begin
    model_reset();
    run_mode(1'b0);
    run_mode(1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule